// File: doc/BRIEF.md
# Rename and Reorder Buffer Unit

This block keeps track of in-flight instructions for a small out-of-order core. Decode hands it up to three instructions per cycle. Each instruction gets a slot in a circular reorder buffer, and that slot is the instruction's rename register. In the same cycle the block resolves every source operand to one of two things. The first is a value, taken from the speculative architectural copy or from a completed in-flight writer. The second is the tag of the youngest in-flight writer of that logical register, which the scheduler then waits on.

Execution units return results on write-back ports, addressed by tag. A result is stored in its slot and is visible to later source lookups. It is also written to the speculative copy of its logical register if that instruction is still the register's latest writer. Completed slots retire from the head in strict program order, up to three per cycle, and update a committed copy of each register. A flush discards all in-flight work and restores the speculative copy from the committed copy.

Top module: `rob_rename_unit`

## Requirements
- R1: After reset the buffer is empty and no retire lane is valid. The first allocation tag is 0, allocation is ready, and every source resolves ready with value 0.
- R2: An accepted group must use contiguous lanes starting at lane 0. Lane i receives tag (tail + i) mod 72, so tag 71 is followed by tag 0 inside one group.
- R3: alloc_ready is 0 when the number of valid lanes exceeds the free slots, or when flush is 1. In that cycle nothing is allocated and the next tag does not change.
- R4: A source whose logical register has no in-flight writer resolves ready, with the speculative copy's value.
- R5: A source whose latest in-flight writer has not completed resolves not ready, with that writer's tag.
- R6: Within a group, a source of lane j that names the destination of an earlier lane i < j resolves not ready. Its tag is that of the latest such earlier lane.
- R7: The cycle after a write-back, any source whose latest writer is that tag resolves ready, with the written value.
- R8: ret_valid is always a prefix of lanes starting at lane 0. Lane i retires slot head + i only if every older slot has completed and retires too, so an incomplete head blocks all retirement. Each retire lane presents the slot's tag, destination and data.
- R9: A retiring slot clears its register's mapping only when it is still that register's latest writer. A younger in-flight writer of the same register stays visible after an older one retires.
- R10: The cycle after flush, the buffer is empty and the next tag is 0. Every source reads the committed value, and uncommitted results are gone.
- R11: After its latest writer retires, a register resolves ready with the retired value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Mispredict recovery: empty the buffer, restore speculative state |
| alloc_valid | input | 3 | Allocation request per lane, contiguous from lane 0 |
| alloc_dst | input | 3x4 | Logical destination per lane |
| alloc_src | input | 3x2x4 | Two logical sources per lane |
| alloc_ready | output | 1 | The whole group is accepted this cycle |
| alloc_tag | output | 3x7 | Slot tag assigned to each lane |
| src_ready | output | 3x2 | Source value is available |
| src_tag | output | 3x2x7 | Producer tag when the source is not ready |
| src_value | output | 3x2x32 | Source value when ready, else 0 |
| wb_valid | input | 3 | Write-back port valid |
| wb_tag | input | 3x7 | Write-back slot tag |
| wb_data | input | 3x32 | Write-back result |
| ret_valid | output | 3 | Retire lane valid (prefix) |
| ret_tag | output | 3x7 | Retiring slot tag |
| ret_dst | output | 3x4 | Retiring logical destination |
| ret_data | output | 3x32 | Retiring value |

## Verification
The hardest states to reach are a completely full buffer at the moment the tail wraps inside one allocation group, and a flush that arrives while a completed younger result sits behind an incomplete older slot. To reach the first, the stimulus retires one slot so the head moves off zero. It then fills the buffer in groups of three that are never written back, so the final group spans tags 70, 71 and 0. The flush case parks an instruction that is never written back in front of a completed writer of a register whose committed value is known. It then checks that the completed value is visible before the flush and that the committed value returns after it. A scoreboard follows every accepted lane in program order, so each retirement is checked for tag, destination and data.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int DEF_LREGS = 16;
    localparam int DEF_DEPTH = 72;
    localparam int DEF_WIDTH = 3;
    localparam int DEF_NWB   = 3;
    localparam int DEF_DW    = 32;

    typedef enum logic [1:0] {
        SRC_ARCH = 2'd0,
        SRC_ROB  = 2'd1,
        SRC_WAIT = 2'd2
    } src_kind_e;

    function automatic int unsigned ring_add(input int unsigned base,
                                             input int unsigned k,
                                             input int unsigned depth);
        int unsigned s;
        s = base + k;
        if (s >= depth) s = s - depth;
        return s;
    endfunction
endpackage

// File: rtl/rob_src_lane.sv
module rob_src_lane
    import rob_pkg::*;
#(
    parameter int LANE  = 0,
    parameter int WIDTH = 3,
    parameter int NSRC  = 2,
    parameter int LW    = 4,
    parameter int TW    = 7,
    parameter int DW    = 32
) (
    input  logic [NSRC-1:0][LW-1:0]  src,
    input  logic [WIDTH-1:0]         grp_vld,
    input  logic [WIDTH-1:0][LW-1:0] grp_dst,
    input  logic [WIDTH-1:0][TW-1:0] grp_tag,
    input  logic [NSRC-1:0]          map_vld,
    input  logic [NSRC-1:0][TW-1:0]  map_tag,
    input  logic [NSRC-1:0]          wr_done,
    input  logic [NSRC-1:0][DW-1:0]  wr_data,
    input  logic [NSRC-1:0][DW-1:0]  arch_data,
    output logic [NSRC-1:0]          rdy,
    output logic [NSRC-1:0][TW-1:0]  tag,
    output logic [NSRC-1:0][DW-1:0]  value
);
    src_kind_e kind [NSRC];

    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            tag[s] = map_tag[s];
            if (!map_vld[s])     kind[s] = SRC_ARCH;
            else if (wr_done[s]) kind[s] = SRC_ROB;
            else                 kind[s] = SRC_WAIT;
            // older lanes of the same group override the table; later lanes win
            for (int i = 0; i < WIDTH; i++) begin
                if (i < LANE && grp_vld[i] && grp_dst[i] == src[s]) begin
                    kind[s] = SRC_WAIT;
                    tag[s]  = grp_tag[i];
                end
            end
            unique case (kind[s])
                SRC_ARCH: begin rdy[s] = 1'b1; value[s] = arch_data[s]; end
                SRC_ROB:  begin rdy[s] = 1'b1; value[s] = wr_data[s];   end
                default:  begin rdy[s] = 1'b0; value[s] = '0;           end
            endcase
        end
    end
endmodule

// File: rtl/rob_retire_pick.sv
module rob_retire_pick
    import rob_pkg::*;
#(
    parameter int DEPTH = 72,
    parameter int WIDTH = 3,
    parameter int TW    = 7,
    parameter int CW    = 7
) (
    input  logic [TW-1:0]            head,
    input  logic [CW-1:0]            cnt,
    input  logic [DEPTH-1:0]         done_vec,
    output logic [WIDTH-1:0]         take,
    output logic [WIDTH-1:0][TW-1:0] idx
);
    logic ok;

    always_comb begin
        ok = 1'b1;
        for (int i = 0; i < WIDTH; i++) begin
            idx[i]  = TW'(ring_add(int'(head), i, DEPTH));
            ok      = ok && (i < int'(cnt)) && done_vec[idx[i]];
            take[i] = ok;
        end
    end
endmodule

// File: rtl/rob_rename_unit.sv
module rob_rename_unit
    import rob_pkg::*;
#(
    parameter int LREGS = DEF_LREGS,
    parameter int DEPTH = DEF_DEPTH,
    parameter int WIDTH = DEF_WIDTH,
    parameter int NSRC  = 2,
    parameter int NWB   = DEF_NWB,
    parameter int DW    = DEF_DW
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                flush,
    input  logic [WIDTH-1:0]                    alloc_valid,
    input  logic [WIDTH-1:0][$clog2(LREGS)-1:0] alloc_dst,
    input  logic [WIDTH-1:0][NSRC-1:0][$clog2(LREGS)-1:0] alloc_src,
    output logic                                alloc_ready,
    output logic [WIDTH-1:0][$clog2(DEPTH)-1:0] alloc_tag,
    output logic [WIDTH-1:0][NSRC-1:0]          src_ready,
    output logic [WIDTH-1:0][NSRC-1:0][$clog2(DEPTH)-1:0] src_tag,
    output logic [WIDTH-1:0][NSRC-1:0][DW-1:0]  src_value,
    input  logic [NWB-1:0]                      wb_valid,
    input  logic [NWB-1:0][$clog2(DEPTH)-1:0]   wb_tag,
    input  logic [NWB-1:0][DW-1:0]              wb_data,
    output logic [WIDTH-1:0]                    ret_valid,
    output logic [WIDTH-1:0][$clog2(DEPTH)-1:0] ret_tag,
    output logic [WIDTH-1:0][$clog2(LREGS)-1:0] ret_dst,
    output logic [WIDTH-1:0][DW-1:0]            ret_data
);
    localparam int LW = $clog2(LREGS);
    localparam int TW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic          done;
        logic [LW-1:0] dst;
        logic [DW-1:0] data;
    } ent_t;

    typedef struct packed {
        logic          vld;
        logic [TW-1:0] tag;
    } map_t;

    typedef struct packed {
        logic [TW-1:0] head;
        logic [TW-1:0] tail;
        logic [CW-1:0] cnt;
    } ptr_t;

    ent_t          ent_q  [DEPTH];
    ent_t          ent_d  [DEPTH];
    map_t          map_q  [LREGS];
    map_t          map_d  [LREGS];
    logic [DW-1:0] spec_q [LREGS];
    logic [DW-1:0] spec_d [LREGS];
    logic [DW-1:0] comm_q [LREGS];
    logic [DW-1:0] comm_d [LREGS];
    ptr_t          ptr_q, ptr_d;
    logic [CW-1:0] occ_q;

    // source lookups
    logic [WIDTH-1:0][NSRC-1:0]          lk_vld, lk_done;
    logic [WIDTH-1:0][NSRC-1:0][TW-1:0]  lk_tag;
    logic [WIDTH-1:0][NSRC-1:0][DW-1:0]  lk_data, lk_arch;

    logic [DEPTH-1:0]         done_vec;
    logic [WIDTH-1:0]         rt_take;
    logic [WIDTH-1:0][TW-1:0] rt_idx;
    int unsigned              nreq, nfree, nalloc, nret;
    logic                     take_alloc;

    assign occ_q = ptr_q.cnt;

    always_comb begin
        for (int l = 0; l < WIDTH; l++) begin
            alloc_tag[l] = TW'(ring_add(int'(ptr_q.tail), l, DEPTH));
            for (int s = 0; s < NSRC; s++) begin
                lk_vld[l][s]  = map_q[alloc_src[l][s]].vld;
                lk_tag[l][s]  = map_q[alloc_src[l][s]].tag;
                lk_done[l][s] = ent_q[lk_tag[l][s]].done;
                lk_data[l][s] = ent_q[lk_tag[l][s]].data;
                lk_arch[l][s] = spec_q[alloc_src[l][s]];
            end
        end
        for (int e = 0; e < DEPTH; e++) done_vec[e] = ent_q[e].done;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        rob_src_lane #(
            .LANE(g), .WIDTH(WIDTH), .NSRC(NSRC), .LW(LW), .TW(TW), .DW(DW)
        ) u_lane (
            .src      (alloc_src[g]),
            .grp_vld  (alloc_valid),
            .grp_dst  (alloc_dst),
            .grp_tag  (alloc_tag),
            .map_vld  (lk_vld[g]),
            .map_tag  (lk_tag[g]),
            .wr_done  (lk_done[g]),
            .wr_data  (lk_data[g]),
            .arch_data(lk_arch[g]),
            .rdy      (src_ready[g]),
            .tag      (src_tag[g]),
            .value    (src_value[g])
        );
    end

    rob_retire_pick #(
        .DEPTH(DEPTH), .WIDTH(WIDTH), .TW(TW), .CW(CW)
    ) u_pick (
        .head    (ptr_q.head),
        .cnt     (ptr_q.cnt),
        .done_vec(done_vec),
        .take    (rt_take),
        .idx     (rt_idx)
    );

    always_comb begin
        nreq        = $countones(alloc_valid);
        nfree       = DEPTH - int'(ptr_q.cnt);
        take_alloc  = !flush && (nreq <= nfree);
        alloc_ready = take_alloc;
        nalloc      = take_alloc ? nreq : 0;
        ret_valid   = rt_take & {WIDTH{!flush}};
        nret        = $countones(ret_valid);
        for (int i = 0; i < WIDTH; i++) begin
            ret_tag[i]  = rt_idx[i];
            ret_dst[i]  = ent_q[rt_idx[i]].dst;
            ret_data[i] = ent_q[rt_idx[i]].data;
        end
    end

    always_comb begin
        ent_d  = ent_q;
        map_d  = map_q;
        spec_d = spec_q;
        comm_d = comm_q;
        ptr_d  = ptr_q;

        // write-back: fill slot, update speculative copy if still the latest writer
        for (int p = 0; p < NWB; p++) begin
            if (wb_valid[p]) begin
                ent_d[wb_tag[p]].done = 1'b1;
                ent_d[wb_tag[p]].data = wb_data[p];
                if (map_q[ent_q[wb_tag[p]].dst].vld &&
                    map_q[ent_q[wb_tag[p]].dst].tag == wb_tag[p])
                    spec_d[ent_q[wb_tag[p]].dst] = wb_data[p];
            end
        end

        // in-order retirement into the committed copy
        for (int i = 0; i < WIDTH; i++) begin
            if (ret_valid[i]) begin
                comm_d[ent_q[rt_idx[i]].dst] = ent_q[rt_idx[i]].data;
                if (map_q[ent_q[rt_idx[i]].dst].vld &&
                    map_q[ent_q[rt_idx[i]].dst].tag == rt_idx[i])
                    map_d[ent_q[rt_idx[i]].dst].vld = 1'b0;
                ent_d[rt_idx[i]].done = 1'b0;
            end
        end

        // allocation: lanes in order, so the youngest writer ends in the table
        if (take_alloc) begin
            for (int l = 0; l < WIDTH; l++) begin
                if (alloc_valid[l]) begin
                    ent_d[alloc_tag[l]].done = 1'b0;
                    ent_d[alloc_tag[l]].dst  = alloc_dst[l];
                    map_d[alloc_dst[l]].vld  = 1'b1;
                    map_d[alloc_dst[l]].tag  = alloc_tag[l];
                end
            end
        end

        ptr_d.head = TW'(ring_add(int'(ptr_q.head), nret, DEPTH));
        ptr_d.tail = TW'(ring_add(int'(ptr_q.tail), nalloc, DEPTH));
        ptr_d.cnt  = CW'(int'(ptr_q.cnt) + nalloc - nret);

        if (flush) begin
            for (int e = 0; e < DEPTH; e++) ent_d[e].done = 1'b0;
            for (int r = 0; r < LREGS; r++) begin
                map_d[r].vld = 1'b0;
                spec_d[r]    = comm_q[r];
            end
            ptr_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) ent_q[e] <= '0;
            for (int r = 0; r < LREGS; r++) begin
                map_q[r]  <= '0;
                spec_q[r] <= '0;
                comm_q[r] <= '0;
            end
            ptr_q <= '0;
        end else begin
            ent_q  <= ent_d;
            map_q  <= map_d;
            spec_q <= spec_d;
            comm_q <= comm_d;
            ptr_q  <= ptr_d;
        end
    end
endmodule

// File: rtl/rob_rename_checks.sv
module rob_rename_checks #(
    parameter int DEPTH = 72,
    parameter int WIDTH = 3,
    parameter int TW    = 7,
    parameter int CW    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             alloc_ready,
    input logic [TW-1:0]    first_tag,
    input logic [WIDTH-1:0] ret_valid,
    input logic [CW-1:0]    occ
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    assert_stall_holds_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready && !flush) |=> $stable(first_tag));

    assert_retire_prefix_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid & (ret_valid + 1'b1)) == '0);

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0 && ret_valid == '0 && first_tag == '0));
endmodule

bind rob_rename_unit rob_rename_checks #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .TW($clog2(DEPTH)), .CW($clog2(DEPTH + 1))
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .alloc_ready(alloc_ready),
    .first_tag  (alloc_tag[0]),
    .ret_valid  (ret_valid),
    .occ        (occ_q)
);

// File: tb/rob_rename_unit_test.sv
module rob_rename_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic [W-1:0]             alloc_valid = '0;
    logic [W-1:0][3:0]        alloc_dst = '0;
    logic [W-1:0][1:0][3:0]   alloc_src = '0;
    logic                     alloc_ready;
    logic [W-1:0][6:0]        alloc_tag;
    logic [W-1:0][1:0]        src_ready;
    logic [W-1:0][1:0][6:0]   src_tag;
    logic [W-1:0][1:0][31:0]  src_value;
    logic [2:0]               wb_valid = '0;
    logic [2:0][6:0]          wb_tag = '0;
    logic [2:0][31:0]         wb_data = '0;
    logic [W-1:0]             ret_valid;
    logic [W-1:0][6:0]        ret_tag;
    logic [W-1:0][3:0]        ret_dst;
    logic [W-1:0][31:0]       ret_data;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct { logic [6:0] tag; logic [3:0] dst; } item_t;
    item_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_rename_unit uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_dst(alloc_dst), .alloc_src(alloc_src),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .src_ready(src_ready), .src_tag(src_tag), .src_value(src_value),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_dst(ret_dst), .ret_data(ret_data)
    );

    function automatic logic [31:0] dfn(input logic [6:0] t);
        return 32'hD000_0000 | (32'(t) * 17 + 5);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lane(input int l, input logic [3:0] d, input logic [3:0] s0, input logic [3:0] s1);
        alloc_dst[l]    = d;
        alloc_src[l][0] = s0;
        alloc_src[l][1] = s1;
    endtask

    task automatic wb(input int p, input logic [6:0] t);
        wb_valid[p] = 1'b1;
        wb_tag[p]   = t;
        wb_data[p]  = dfn(t);
    endtask

    task automatic settle();
        #1;
    endtask

    // ends the cycle: records accepted lanes, crosses the clock edge, clears pulses
    task automatic advance();
        if (flush) sbq.delete();
        else if (alloc_ready)
            for (int l = 0; l < W; l++)
                if (alloc_valid[l]) sbq.push_back('{alloc_tag[l], alloc_dst[l]});
        @(negedge clk);
        alloc_valid = '0;
        wb_valid    = '0;
        flush       = 1'b0;
    endtask

    // scoreboard monitor: retirements must follow allocation order
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            for (int i = 0; i < W; i++) begin
                if (ret_valid[i]) begin
                    if (sbq.size() == 0) begin
                        chk("R8 unexpected retire", 64'(ret_tag[i]), 64'h7f);
                    end else begin
                        item_t it;
                        it = sbq.pop_front();
                        chk("R8 retire tag",  64'(ret_tag[i]),  64'(it.tag));
                        chk("R8 retire dst",  64'(ret_dst[i]),  64'(it.dst));
                        chk("R8 retire data", 64'(ret_data[i]), 64'(dfn(it.tag)));
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        lane(0, 4'd0, 4'd5, 4'd0);
        settle();
        chk("R1 first tag", 64'(alloc_tag[0]), 0);
        chk("R1 ret idle", 64'(ret_valid), 0);
        chk("R1 ready", 64'(alloc_ready), 1);
        chk("R1 src ready", 64'(src_ready[0][0]), 1);
        chk("R1 src value", 64'(src_value[0][0]), 0);
        advance();

        // R2/R4/R6 three-lane group
        lane(0, 4'd1, 4'd2, 4'd3);
        lane(1, 4'd2, 4'd1, 4'd4);
        lane(2, 4'd1, 4'd2, 4'd1);
        alloc_valid = 3'b111;
        settle();
        chk("R2 tag lane0", 64'(alloc_tag[0]), 0);
        chk("R2 tag lane2", 64'(alloc_tag[2]), 2);
        chk("R4 arch ready", 64'(src_ready[0][0]), 1);
        chk("R4 arch value", 64'(src_value[0][0]), 0);
        chk("R6 l1 ready", 64'(src_ready[1][0]), 0);
        chk("R6 l1 tag", 64'(src_tag[1][0]), 0);
        chk("R6 l2 s0 tag", 64'(src_tag[2][0]), 1);
        chk("R6 l2 s1 tag", 64'(src_tag[2][1]), 0);
        advance();

        // R5 latest in-flight writer
        lane(0, 4'd0, 4'd1, 4'd2);
        wb(0, 7'd1);
        settle();
        chk("R5 r1 ready", 64'(src_ready[0][0]), 0);
        chk("R5 r1 tag", 64'(src_tag[0][0]), 2);
        chk("R5 r2 tag", 64'(src_tag[0][1]), 1);
        chk("R2 next tag", 64'(alloc_tag[0]), 3);
        advance();

        // R7 forwarded value; R8 head blocks
        lane(0, 4'd0, 4'd2, 4'd0);
        wb(1, 7'd2);
        wb(2, 7'd0);
        settle();
        chk("R7 ready", 64'(src_ready[0][0]), 1);
        chk("R7 value", 64'(src_value[0][0]), 64'(dfn(7'd1)));
        chk("R8 blocked", 64'(ret_valid), 0);
        advance();
        settle();
        chk("R8 three retire", 64'(ret_valid), 3'b111);
        advance();

        // R11 committed values
        lane(0, 4'd0, 4'd1, 4'd2);
        settle();
        chk("R11 r1", 64'(src_value[0][0]), 64'(dfn(7'd2)));
        chk("R11 r1 ready", 64'(src_ready[0][0]), 1);
        chk("R11 r2", 64'(src_value[0][1]), 64'(dfn(7'd1)));
        advance();

        // R9 older writer retires, younger mapping stays
        lane(0, 4'd5, 4'd0, 4'd0);
        lane(1, 4'd5, 4'd0, 4'd0);
        alloc_valid = 3'b011;
        advance();
        wb(0, 7'd3);
        advance();
        settle();
        chk("R8 single", 64'(ret_valid), 3'b001);
        advance();
        lane(0, 4'd0, 4'd5, 4'd0);
        wb(0, 7'd4);
        settle();
        chk("R9 ready", 64'(src_ready[0][0]), 0);
        chk("R9 tag", 64'(src_tag[0][0]), 4);
        advance();
        advance();
        lane(0, 4'd0, 4'd5, 4'd0);
        settle();
        chk("R11 r5", 64'(src_value[0][0]), 64'(dfn(7'd4)));
        advance();

        // R10 flush discards uncommitted result
        lane(0, 4'd6, 4'd0, 4'd0);
        lane(1, 4'd1, 4'd0, 4'd0);
        alloc_valid = 3'b011;
        advance();
        wb(0, 7'd6);
        advance();
        lane(0, 4'd0, 4'd1, 4'd6);
        settle();
        chk("R7 r1 spec", 64'(src_value[0][0]), 64'(dfn(7'd6)));
        chk("R5 r6 waits", 64'(src_ready[0][1]), 0);
        flush = 1'b1;
        settle();
        chk("R3 flush blocks", 64'(alloc_ready), 0);
        advance();
        lane(0, 4'd0, 4'd1, 4'd6);
        settle();
        chk("R10 r1 committed", 64'(src_value[0][0]), 64'(dfn(7'd2)));
        chk("R10 r6 committed", 64'(src_value[0][1]), 0);
        chk("R10 r6 ready", 64'(src_ready[0][1]), 1);
        chk("R10 tag zero", 64'(alloc_tag[0]), 0);
        chk("R10 ret idle", 64'(ret_valid), 0);
        advance();

        // R2/R3 wrap and full buffer
        lane(0, 4'd9, 4'd0, 4'd0);
        alloc_valid = 3'b001;
        advance();
        wb(0, 7'd0);
        advance();
        advance();
        for (int g = 0; g < 23; g++) begin
            lane(0, 4'd10, 4'd0, 4'd0);
            lane(1, 4'd10, 4'd0, 4'd0);
            lane(2, 4'd10, 4'd0, 4'd0);
            alloc_valid = 3'b111;
            advance();
        end
        alloc_valid = 3'b111;
        settle();
        chk("R2 wrap ready", 64'(alloc_ready), 1);
        chk("R2 wrap lane0", 64'(alloc_tag[0]), 70);
        chk("R2 wrap lane1", 64'(alloc_tag[1]), 71);
        chk("R2 wrap lane2", 64'(alloc_tag[2]), 0);
        advance();
        alloc_valid = 3'b001;
        settle();
        chk("R3 full stall", 64'(alloc_ready), 0);
        advance();
        settle();
        chk("R3 tag held", 64'(alloc_tag[0]), 1);
        wb(0, 7'd1);
        advance();
        advance();
        alloc_valid = 3'b011;
        settle();
        chk("R3 two over one", 64'(alloc_ready), 0);
        alloc_valid = 3'b001;
        settle();
        chk("R3 one fits", 64'(alloc_ready), 1);
        chk("R3 tag after retire", 64'(alloc_tag[0]), 1);
        advance();
        flush = 1'b1;
        advance();
        @(negedge clk);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule